// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel Controller

This block is the control core of a single bus-master audio DMA channel. Software sets a base address for a ring of 32 buffer descriptors, each 8 bytes long. It also sets the index of the last descriptor it has filled, and then starts the channel. The channel walks the ring. For each descriptor it reads the entry through a request/response memory port, loads the sample length, and counts one sample per accepted handshake on a valid/ready sample interface. When the count runs out, it moves on to the next descriptor. The real data movement and sample formatting belong to a separate datapath. This block only counts transfers and tracks the ring position.

Completion events set write-one-to-clear status flags and may raise an interrupt request. A buffer completes when a descriptor asks for an interrupt. The last-valid completion happens when the ring reaches the last valid index. When the channel stops at the last valid index, it reports halted. Software restarts it by writing a new last valid index.

The control core is a three-state machine. IDLE means halted. FETCH means a descriptor read is outstanding. MOVE means samples are being counted. The transitions are:
- IDLE→FETCH on a run write or on a restarting last-index write.
- FETCH→MOVE when a descriptor with a non-zero length arrives.
- FETCH→FETCH when a zero-length descriptor is skipped.
- FETCH→IDLE when a zero-length descriptor sits at the last valid index.
- MOVE→FETCH when a descriptor completes before the last valid index.
- MOVE→IDLE when a descriptor completes at the last valid index.
- Any state→IDLE on a stop write or a register-clear write.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset the descriptor base, all three indices, the remaining count and control read as zero. Status reads 0x0001 (halted only), and `irq` and `hold_last` are low.
- R2: Register writes are decoded by byte offset. Byte and half-word values arrive in the low bits of `wr_data`. A write at offset 0x0 stores the base with bits 1:0 forced to zero. Descriptor n is requested at base + 8·n. A response carries word 1 in bits 63:32 and word 0 in bits 31:0. In word 1, bits 15:0 are the length, bit 31 requests a completion flag and bit 30 selects repeat-last-sample.
- R3: A control write at offset 0xB with bit 0 (run) set and bit 1 clear does the following: it copies the prefetch index into the current index, increments the prefetch index modulo 32, starts a descriptor fetch and clears status bit 0 (halted). A control write with run clear sets halted and stops the channel.
- R4: `smp_ready` is high only while descriptor samples remain and no register write is present. Each accepted handshake decrements the remaining count by one. Handshakes during a fetch or while halted change nothing.
- R5: When the count reaches zero before the last valid index, the channel clears status bit 1 (current-equals-last) and sets bit 3 (buffer done) if the descriptor's bit 31 is set. It then advances to the next descriptor and fetches it.
- R6: When the count reaches zero at the last valid index, the channel sets status bits 2, 1 and 0 and halts. `hold_last` then shows the descriptor's bit 30 until the channel is restarted.
- R7: A write at offset 0x5 stores the value modulo 32 as the last valid index. If run is set and the channel is halted, the same write clears status bits 1:0, advances one descriptor and fetches it.
- R8: Writing ones to status (offset 0x6) clears the matching bits among bits 4:2. Writing to bits 1:0 has no effect.
- R9: `irq` rises when the pending status bits change and either bit 2 is pending with control bit 2 set, or bit 3 is pending with control bit 4 set. `irq` falls when bits 4:2 all become clear.
- R10: A control write with bit 1 set zeroes the base, the indices and the count, and sets status to 0x0001. It keeps the existing control bits 4:2, clears run and stops the channel.
- R11: A fetched zero-length descriptor is skipped at once to the next descriptor. If that descriptor is at the last valid index, the channel sets status bit 0 and halts instead.
- R12: Reads select a word by `rd_addr[3:2]`:
  - word 0 is the base;
  - word 1 is {status, 8-bit last index, 8-bit current index};
  - word 2 is {control, 8-bit prefetch index, count}.

  Writes to offsets 0x4, 0x8 and 0xA are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the register written |
| wr_data | input | 32 | Write value, low-aligned |
| rd_addr | input | 4 | Read offset; bits 3:2 select the word |
| rd_data | output | 32 | Read word (combinational) |
| mem_req | output | 1 | Descriptor read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the requested descriptor |
| mem_ack | input | 1 | Descriptor response valid |
| mem_rdata | input | 64 | Descriptor contents, word 1 in the upper half |
| smp_valid | input | 1 | Sample offered by the datapath |
| smp_ready | output | 1 | Sample accepted this cycle when valid |
| irq | output | 1 | Interrupt request level |
| hold_last | output | 1 | Repeat-last-sample policy of the final descriptor |

## Verification
The hardest state to reach from the ports is the wrap of the prefetch and current indices from 31 back to 0, because it needs 32 descriptor advances. The bench fills the whole ring with zero-length descriptors and sets the last valid index to 31. The channel then sweeps the ring through back-to-back fetches without a single sample, halts at entry 31 with the prefetch index already wrapped, and a restarting last-index write then carries the current index across the wrap. The ordering of the pending-flag interrupt rules is reached the same way, by clearing one flag while the other remains pending.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_FETCH = 2'd1,
        CH_MOVE  = 2'd2
    } ch_state_e;

    // status bit positions (software decodes these)
    localparam int SB_HALTED    = 0;
    localparam int SB_AT_LAST   = 1;
    localparam int SB_LAST_DONE = 2;
    localparam int SB_BUF_DONE  = 3;
    localparam int SB_FIFO_ERR  = 4;

    // control bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_CLEAR   = 1;
    localparam int CB_LAST_IE = 2;
    localparam int CB_ERR_IE  = 3;
    localparam int CB_DONE_IE = 4;

    // register byte offsets
    localparam logic [3:0] OFS_BASE = 4'h0;
    localparam logic [3:0] OFS_LAST = 4'h5;
    localparam logic [3:0] OFS_STAT = 4'h6;
    localparam logic [3:0] OFS_CTRL = 4'hB;

    localparam logic [4:0] CTRL_KEEP  = 5'b11100;
    localparam logic [4:0] STAT_RESET = 5'b00001;

endpackage

// File: rtl/ring_dma_desc_port.sv
module ring_dma_desc_port #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 16
) (
    input  logic [31:0]      base,
    input  logic [IDX_W-1:0] idx,
    input  logic [63:0]      rdata,
    output logic [31:0]      addr,
    output logic [CNT_W-1:0] len,
    output logic             ioc,
    output logic             rep
);
    localparam int STRIDE_SH = 3;
    localparam int W1_LO     = 32;

    assign addr = base + (32'(idx) << STRIDE_SH);
    assign len  = rdata[W1_LO +: CNT_W];
    assign ioc  = rdata[63];
    assign rep  = rdata[62];

    // buffer address and spare control bits belong to the datapath
    logic unused_desc;
    assign unused_desc = ^{rdata[31:0], rdata[61:W1_LO+CNT_W]};
endmodule

// File: rtl/ring_dma_readmux.sv
module ring_dma_readmux #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 16
) (
    input  logic [3:0]       rd_addr,
    input  logic [31:0]      base,
    input  logic [4:0]       stat,
    input  logic [4:0]       ctrl,
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] last,
    input  logic [IDX_W-1:0] pref,
    input  logic [CNT_W-1:0] remain,
    output logic [31:0]      rd_data
);
    always_comb begin
        unique case (rd_addr[3:2])
            2'd0:    rd_data = base;
            2'd1:    rd_data = {16'(stat), 8'(last), 8'(cur)};
            2'd2:    rd_data = {8'(ctrl), 8'(pref), 16'(remain)};
            default: rd_data = '0;
        endcase
    end

    logic unused_rd;
    assign unused_rd = ^rd_addr[1:0];
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
    import ring_dma_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [63:0] mem_rdata,
    input  logic        smp_valid,
    output logic        smp_ready,
    output logic        irq,
    output logic        hold_last
);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ch_state_e        st_q, st_n;
    logic [31:0]      base_q, base_n;
    logic [IDX_W-1:0] cur_q, cur_n, last_q, last_n, pref_q, pref_n;
    logic [CNT_W-1:0] remain_q, remain_n;
    logic [4:0]       stat_q, stat_n, ctrl_q, ctrl_n;
    logic             ioc_q, ioc_n, rep_q, rep_n, hold_q, hold_n, irq_q, irq_n;

    logic [CNT_W-1:0] d_len;
    logic             d_ioc, d_rep;
    logic             smp_fire;

    ring_dma_desc_port #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_desc (
        .base (base_q),
        .idx  (cur_q),
        .rdata(mem_rdata),
        .addr (mem_addr),
        .len  (d_len),
        .ioc  (d_ioc),
        .rep  (d_rep)
    );

    ring_dma_readmux #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_rmux (
        .rd_addr(rd_addr),
        .base   (base_q),
        .stat   (stat_q),
        .ctrl   (ctrl_q),
        .cur    (cur_q),
        .last   (last_q),
        .pref   (pref_q),
        .remain (remain_q),
        .rd_data(rd_data)
    );

    assign mem_req   = (st_q == CH_FETCH);
    assign smp_ready = (st_q == CH_MOVE) && !wr_en;
    assign smp_fire  = smp_valid && smp_ready;
    assign irq       = irq_q;
    assign hold_last = hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CH_IDLE;
            base_q   <= '0;
            cur_q    <= '0;
            last_q   <= '0;
            pref_q   <= '0;
            remain_q <= '0;
            stat_q   <= STAT_RESET;
            ctrl_q   <= '0;
            ioc_q    <= 1'b0;
            rep_q    <= 1'b0;
            hold_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            st_q     <= st_n;
            base_q   <= base_n;
            cur_q    <= cur_n;
            last_q   <= last_n;
            pref_q   <= pref_n;
            remain_q <= remain_n;
            stat_q   <= stat_n;
            ctrl_q   <= ctrl_n;
            ioc_q    <= ioc_n;
            rep_q    <= rep_n;
            hold_q   <= hold_n;
            irq_q    <= irq_n;
        end
    end

    // next state and register effects
    always_comb begin
        st_n     = st_q;
        base_n   = base_q;
        cur_n    = cur_q;
        last_n   = last_q;
        pref_n   = pref_q;
        remain_n = remain_q;
        stat_n   = stat_q;
        ctrl_n   = ctrl_q;
        ioc_n    = ioc_q;
        rep_n    = rep_q;
        hold_n   = hold_q;
        irq_n    = irq_q;

        unique case (st_q)
            CH_IDLE: ;
            CH_FETCH: begin
                if (mem_ack) begin
                    remain_n = d_len;
                    ioc_n    = d_ioc;
                    rep_n    = d_rep;
                    if (d_len != '0) begin
                        st_n = CH_MOVE;
                    end else if (cur_q == last_q) begin
                        stat_n[SB_HALTED] = 1'b1;
                        st_n              = CH_IDLE;
                    end else begin
                        cur_n  = pref_q;
                        pref_n = pref_q + IDX_ONE;
                    end
                end
            end
            CH_MOVE: begin
                if (smp_fire) begin
                    remain_n = remain_q - CNT_ONE;
                    if (remain_q == CNT_ONE) begin
                        stat_n[SB_AT_LAST] = 1'b0;
                        if (ioc_q) stat_n[SB_BUF_DONE] = 1'b1;
                        if (cur_q == last_q) begin
                            stat_n[SB_LAST_DONE] = 1'b1;
                            stat_n[SB_AT_LAST]   = 1'b1;
                            stat_n[SB_HALTED]    = 1'b1;
                            hold_n               = rep_q;
                            st_n                 = CH_IDLE;
                        end else begin
                            cur_n  = pref_q;
                            pref_n = pref_q + IDX_ONE;
                            st_n   = CH_FETCH;
                        end
                    end
                end
            end
            default: st_n = CH_IDLE;
        endcase

        if (wr_en) begin
            case (wr_addr)
                OFS_BASE: base_n = {wr_data[31:2], 2'b00};
                OFS_LAST: begin
                    last_n = wr_data[IDX_W-1:0];
                    if (ctrl_q[CB_RUN] && stat_q[SB_HALTED]) begin
                        stat_n[SB_HALTED]  = 1'b0;
                        stat_n[SB_AT_LAST] = 1'b0;
                        cur_n              = pref_q;
                        pref_n             = pref_q + IDX_ONE;
                        hold_n             = 1'b0;
                        st_n               = CH_FETCH;
                    end
                end
                OFS_STAT: stat_n[4:2] = stat_n[4:2] & ~wr_data[4:2];
                OFS_CTRL: begin
                    if (wr_data[CB_CLEAR]) begin
                        base_n   = '0;
                        cur_n    = '0;
                        last_n   = '0;
                        pref_n   = '0;
                        remain_n = '0;
                        stat_n   = STAT_RESET;
                        ctrl_n   = ctrl_q & CTRL_KEEP;
                        st_n     = CH_IDLE;
                    end else begin
                        ctrl_n = wr_data[4:0];
                        if (wr_data[CB_RUN]) begin
                            cur_n             = pref_q;
                            pref_n            = pref_q + IDX_ONE;
                            stat_n[SB_HALTED] = 1'b0;
                            hold_n            = 1'b0;
                            st_n              = CH_FETCH;
                        end else begin
                            stat_n[SB_HALTED] = 1'b1;
                            st_n              = CH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (stat_q[4:2] != stat_n[4:2]) begin
            if (stat_n[4:2] == 3'b000) begin
                irq_n = 1'b0;
            end else if ((stat_n[SB_LAST_DONE] && ctrl_q[CB_LAST_IE]) ||
                         (stat_n[SB_BUF_DONE]  && ctrl_q[CB_DONE_IE])) begin
                irq_n = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic             mem_req,
    input logic             irq,
    input logic [4:0]       stat,
    input logic [IDX_W-1:0] cur,
    input logic [IDX_W-1:0] pref,
    input logic [CNT_W-1:0] remain
);
    // R4: no sample is taken while the channel reports halted
    assert_ready_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> !stat[0]);

    // R4: fetch and sample acceptance never overlap
    assert_fetch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && smp_ready));

    // R4: one accepted sample lowers the count by exactly one
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> (remain == $past(remain) - CNT_W'(1)));

    // R3: a fetch is only outstanding on a running channel
    assert_fetch_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !stat[0]);

    // R3: prefetch index stays one ahead of the current index, modulo the ring
    assert_prefetch_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pref == cur + IDX_W'(1)) || (pref == '0 && cur == '0));

    // R9: no request while no interrupt status bit is pending
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[4:2] == 3'b000) |-> !irq);
endmodule

bind ring_dma_chan ring_dma_chan_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready),
    .mem_req  (mem_req),
    .irq      (irq),
    .stat     (stat_q),
    .cur      (cur_q),
    .pref     (pref_q),
    .remain   (remain_q)
);

// File: tb/test_ring_dma_chan.sv
module test_ring_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        smp_valid;
    logic        smp_ready;
    logic        irq;
    logic        hold_last;

    logic [63:0] mem [32];
    logic [1:0]  lat;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ring_dma_chan i_ring_dma_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .irq(irq), .hold_last(hold_last)
    );

    // descriptor memory model: answers a held request two cycles later
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat       <= '0;
        end else if (mem_req && !mem_ack) begin
            if (lat == 2'd1) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[7:3]];
                lat       <= '0;
            end else begin
                lat <= lat + 2'd1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic settle();
        int n = 0;
        @(negedge clk);
        while (mem_req && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic send(input int n);
        int sent = 0;
        int guard = 0;
        while (sent < n && guard < 500) begin
            @(negedge clk);
            guard++;
            if (smp_ready) begin
                smp_valid = 1'b1;
                sent++;
            end else begin
                smp_valid = 1'b0;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); chk("R1 base after reset", v, 32'h0);
        rd(4'h4, v); chk("R1 status/indices after reset", v, 32'h0001_0000);
        rd(4'h8, v); chk("R1 control/count after reset", v, 32'h0);
        chk("R1 irq/hold after reset", {30'd0, irq, hold_last}, 32'h0);
    endtask

    task automatic t_ring_advance();
        logic [31:0] v;
        mem[0] = {32'h8000_0003, 32'h0000_1000};
        mem[1] = {32'h0000_0002, 32'h0000_2000};
        wr(4'h0, 32'h0000_0103);
        rd(4'h0, v); chk("R2 base low bits forced", v, 32'h0000_0100);
        wr(4'h5, 32'h1);
        wr(4'hB, 32'h11);
        chk("R4 fetch pending, no sample accepted", {30'd0, mem_req, smp_ready}, 32'h2);
        chk("R2 descriptor address", mem_addr, 32'h0000_0100);
        settle();
        rd(4'h4, v); chk("R3 run start indices/status", v, 32'h0000_0100);
        rd(4'h8, v); chk("R3 prefetch and loaded count", v, 32'h1101_0003);
        send(3);
        settle();
        rd(4'h4, v); chk("R5 buffer done and advance", v, 32'h0008_0101);
        rd(4'h8, v); chk("R5 next descriptor fetched", v, 32'h1102_0002);
        chk("R9 irq on buffer done", {31'd0, irq}, 32'h1);
        wr(4'h6, 32'h08);
        chk("R9 irq falls when flags clear", {31'd0, irq}, 32'h0);
        send(2);
        rd(4'h4, v); chk("R6 last-valid halt status", v, 32'h0007_0101);
        chk("R9 no irq with last enable off", {31'd0, irq}, 32'h0);
        chk("R6 hold_last from clear bit 30", {31'd0, hold_last}, 32'h0);
    endtask

    task automatic t_status_and_restart();
        logic [31:0] v;
        mem[2] = {32'h4000_0004, 32'h0000_3000};
        wr(4'h6, 32'h03);
        rd(4'h4, v); chk("R8 read-only status bits kept", v, 32'h0007_0101);
        wr(4'h6, 32'h04);
        rd(4'h4, v); chk("R8 last-done cleared", v, 32'h0003_0101);
        wr(4'h5, 32'h22);
        settle();
        rd(4'h4, v); chk("R7 last-index restart", v, 32'h0000_0202);
        rd(4'h8, v); chk("R7 restart fetched next", v, 32'h1103_0004);
    endtask

    task automatic t_last_irq();
        logic [31:0] v;
        mem[3] = {32'h4000_0001, 32'h0000_4000};
        wr(4'h5, 32'h3);
        wr(4'hB, 32'h05);
        settle();
        rd(4'h8, v); chk("R3 run write while running advances", v, 32'h0504_0001);
        send(1);
        rd(4'h4, v); chk("R6 halt at last index", v, 32'h0007_0303);
        chk("R9 irq on last-valid done", {31'd0, irq}, 32'h1);
        chk("R6 hold_last set from bit 30", {31'd0, hold_last}, 32'h1);
        wr(4'h6, 32'h04);
        chk("R9 irq falls after last-done clear", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_reg_clear();
        logic [31:0] v;
        wr(4'hB, 32'h1E);
        rd(4'h0, v); chk("R10 base cleared", v, 32'h0);
        rd(4'h4, v); chk("R10 status halted only", v, 32'h0001_0000);
        rd(4'h8, v); chk("R10 enables kept, run cleared", v, 32'h0400_0000);
        wr(4'h4, 32'h1F);
        wr(4'h8, 32'hFFFF);
        wr(4'hA, 32'h07);
        rd(4'h4, v); chk("R12 current-index write ignored", v, 32'h0001_0000);
        rd(4'h8, v); chk("R12 count/prefetch writes ignored", v, 32'h0400_0000);
    endtask

    task automatic t_zero_len();
        logic [31:0] v;
        mem[0] = 64'h0;
        mem[1] = {32'h0000_0002, 32'h0};
        mem[2] = 64'h0;
        mem[3] = {32'h0000_0005, 32'h0};
        wr(4'h0, 32'h200);
        wr(4'h5, 32'h1);
        wr(4'hB, 32'h01);
        settle();
        rd(4'h4, v); chk("R11 zero length skipped", v, 32'h0000_0101);
        rd(4'h8, v); chk("R11 skip loaded next count", v, 32'h0102_0002);
        wr(4'h5, 32'h2);
        send(2);
        settle();
        rd(4'h4, v); chk("R11 zero length at last halts", v, 32'h0001_0202);
        chk("R4 ready low while halted", {31'd0, smp_ready}, 32'h0);
    endtask

    task automatic t_run_clear();
        logic [31:0] v;
        wr(4'h5, 32'h4);
        settle();
        rd(4'h8, v); chk("R7 restart at index 3", v, 32'h0104_0005);
        send(2);
        rd(4'h8, v); chk("R4 count after two samples", v, 32'h0104_0003);
        wr(4'hB, 32'h00);
        rd(4'h4, v); chk("R3 run clear sets halted", v, 32'h0001_0403);
        repeat (4) begin
            @(negedge clk);
            smp_valid = 1'b1;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        rd(4'h8, v); chk("R4 samples ignored while halted", v, 32'h0004_0003);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(4'hB, 32'h02);
        wr(4'h0, 32'h300);
        for (int i = 0; i < 32; i++) mem[i] = 64'h0;
        wr(4'h5, 32'd31);
        wr(4'hB, 32'h01);
        settle();
        rd(4'h4, v); chk("R11 sweep halts at index 31", v, 32'h0001_1F1F);
        rd(4'h8, v); chk("R3 prefetch wraps modulo 32", v, 32'h0100_0000);
        mem[0] = {32'h0000_0005, 32'h0};
        wr(4'h5, 32'h0);
        settle();
        rd(4'h4, v); chk("R7 current index wraps to 0", v, 32'h0000_0000);
        rd(4'h8, v); chk("R7 wrapped fetch count", v, 32'h0101_0005);
    endtask

    initial begin
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; smp_valid = 1'b0;
        for (int i = 0; i < 32; i++) mem[i] = 64'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ring_advance();
        t_status_and_restart();
        t_last_irq();
        t_reg_clear();
        t_zero_len();
        t_run_clear();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule